// File: doc/BRIEF.md
# PCI Interrupt Steering Router

The block takes four level-sensitive PCI interrupt sources and steers each one onto one of sixteen legacy interrupt-controller request lines. The sixteen lines stand for two cascaded eight-input controllers. Each source has its own 8-bit routing byte, which holds a line number. A line is driven high while at least one source steered to it is high.

Internally the block keeps one level bit for every (line, source) pair. An input edge updates only that source's bit under its current line. Any configuration write that lands on a routing byte clears the whole level vector. The vector is then refilled from the live input levels under the new routing, so a line never keeps a level left behind by a source that has moved away.

Routing bytes are written through a byte-addressed port that carries up to four data bytes and a length. They are read back one byte at a time through a separate combinational read address.

Top module: `pirq_steer_router`

## Requirements
- R1: After reset every routing byte reads 0x80 and all sixteen lines are low.
- R2: The routing byte of source n sits at byte address 0x60+n. A write of length 1, 2 or 4 puts data byte k (bits 8k+7:8k) at address addr+k. A read of 0x60..0x63 returns the stored byte. A read of any other address returns 0.
- R3: A source whose routing byte is 16 or more is steered nowhere, and its level has no effect on any line.
- R4: One cycle after the inputs are sampled, line l is high exactly when some source with a routing byte equal to l was high at that sample.
- R5: A level change on one source alters only the line that source is steered to. Every other line holds.
- R6: A write that touches a routing byte rebuilds all lines from the live input levels under the new routing. The rebuilt state shows on the cycle after the write.
- R7: Bytes of a write that fall outside 0x60..0x63 are ignored. A write that lies wholly outside the window changes nothing.
- R8: A write whose length is not 1, 2 or 4 is ignored entirely.
- R9: Sources sharing a line combine as an OR. The line stays high until the last of them drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_lvl_i | input | 4 | Levels of the PCI interrupt sources, bit n is source n |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Byte address of the first write byte |
| cfg_wdata_i | input | 32 | Write data, byte k goes to cfg_addr_i+k |
| cfg_len_i | input | 3 | Write length in bytes (1, 2 or 4) |
| cfg_raddr_i | input | 8 | Read byte address |
| cfg_rdata_o | output | 8 | Read data for cfg_raddr_i |
| line_o | output | 16 | Interrupt-controller request lines |

## Verification
The bench moves a source that is high from one line to another. A design that skipped the rebuild would leave the old line stuck high. Two sources are stacked on one line and dropped one at a time, which catches a line driven by a single source instead of an OR. Routing values 16 and 15 are tried on either side of the disable boundary, so an off-by-one would light a line or lose one. Writes that straddle both edges of the window, and writes with illegal lengths, would corrupt routing bytes in a design that decoded lanes or lengths loosely.

// File: rtl/pirq_steer_pkg.sv
package pirq_steer_pkg;
  localparam int unsigned ROUTE_W = 8;
  localparam int unsigned LEN_W   = 3;

  typedef logic [ROUTE_W-1:0] route_t;

  function automatic logic len_legal(input logic [LEN_W-1:0] len);
    return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_steer_pkg::*;
#(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  parameter route_t RST_ROUTE       = 8'h80
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [8*DATA_BYTES-1:0]   wdata_i,
  input  logic [LEN_W-1:0]          len_i,
  input  logic [ADDR_W-1:0]         raddr_i,
  output route_t [N_SRC-1:0]        route_q_o,
  output route_t [N_SRC-1:0]        route_d_o,
  output logic                      hit_o,
  output route_t                    rdata_o
);
  localparam int unsigned EXT_W  = ADDR_W + 1;
  localparam int unsigned LANE_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

  logic [EXT_W-1:0] lo, hi;
  logic [N_SRC-1:0] sel;
  logic             len_ok;

  assign lo     = {1'b0, addr_i};
  assign hi     = lo + EXT_W'(len_i);
  assign len_ok = len_legal(len_i);

  for (genvar s = 0; s < N_SRC; s++) begin : g_slot
    localparam logic [EXT_W-1:0] SLOT = EXT_W'(BASE) + EXT_W'(s);
    logic [EXT_W-1:0]  diff;
    logic [LANE_W-1:0] lane;
    route_t            q;

    assign diff   = SLOT - lo;
    assign lane   = diff[LANE_W-1:0];
    assign sel[s] = we_i && len_ok && (SLOT >= lo) && (SLOT < hi);
    assign route_d_o[s] = sel[s] ? wdata_i[lane*8 +: 8] : q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_ROUTE;
      else         q <= route_d_o[s];
    end

    assign route_q_o[s] = q;
  end

  assign hit_o = |sel;

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if ({1'b0, raddr_i} == EXT_W'(BASE) + EXT_W'(s)) rdata_o = route_q_o[s];
    end
  end
endmodule

// File: rtl/pirq_level_track.sv
module pirq_level_track
  import pirq_steer_pkg::*;
#(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned N_LINE = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_SRC-1:0]          src_i,
  input  logic                      rebuild_i,
  input  route_t [N_SRC-1:0]        route_i,
  output logic [N_LINE*N_SRC-1:0]   lvl_o
);
  localparam int unsigned SRC_W  = (N_SRC  > 1) ? $clog2(N_SRC)  : 1;
  localparam int unsigned LINE_W = (N_LINE > 1) ? $clog2(N_LINE) : 1;
  localparam int unsigned IDX_W  = SRC_W + LINE_W;
  localparam int unsigned VEC_W  = N_LINE * N_SRC;

  logic [VEC_W-1:0] lvl_q, lvl_d;
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] en;
  logic [N_SRC-1:0][IDX_W-1:0] idx;

  // bit position of (line, source) is line*N_SRC + source; N_SRC is a power of two
  for (genvar s = 0; s < N_SRC; s++) begin : g_idx
    assign en[s]  = route_i[s] < ROUTE_W'(N_LINE);
    assign idx[s] = {route_i[s][LINE_W-1:0], SRC_W'(s)};
  end

  always_comb begin
    lvl_d = rebuild_i ? '0 : lvl_q;
    for (int s = 0; s < N_SRC; s++) begin
      if ((rebuild_i || (src_i[s] != src_q[s])) && en[s]) lvl_d[idx[s]] = src_i[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      src_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      src_q <= src_i;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pirq_line_reduce.sv
module pirq_line_reduce #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned N_LINE = 16
) (
  input  logic [N_LINE*N_SRC-1:0] lvl_i,
  output logic [N_LINE-1:0]       line_o
);
  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    assign line_o[l] = |lvl_i[l*N_SRC +: N_SRC];
  end
endmodule

// File: rtl/pirq_steer_router.sv
module pirq_steer_router
  import pirq_steer_pkg::*;
#(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned N_LINE     = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  parameter route_t RST_ROUTE       = 8'h80
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_lvl_i,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-1:0]       cfg_addr_i,
  input  logic [8*DATA_BYTES-1:0] cfg_wdata_i,
  input  logic [LEN_W-1:0]        cfg_len_i,
  input  logic [ADDR_W-1:0]       cfg_raddr_i,
  output logic [ROUTE_W-1:0]      cfg_rdata_o,
  output logic [N_LINE-1:0]       line_o
);
  route_t [N_SRC-1:0]        route_q, route_d;
  logic                      hit;
  logic [N_LINE*N_SRC-1:0]   lvl;

  pirq_route_regs #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES),
    .BASE(BASE), .RST_ROUTE(RST_ROUTE)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .len_i    (cfg_len_i),
    .raddr_i  (cfg_raddr_i),
    .route_q_o(route_q),
    .route_d_o(route_d),
    .hit_o    (hit),
    .rdata_o  (cfg_rdata_o)
  );

  pirq_level_track #(.N_SRC(N_SRC), .N_LINE(N_LINE)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_lvl_i),
    .rebuild_i(hit),
    .route_i  (route_d),
    .lvl_o    (lvl)
  );

  pirq_line_reduce #(.N_SRC(N_SRC), .N_LINE(N_LINE)) u_reduce (
    .lvl_i (lvl),
    .line_o(line_o)
  );
endmodule

// File: rtl/pirq_steer_router_chk.sv
module pirq_steer_router_chk
  import pirq_steer_pkg::*;
#(
  parameter int unsigned N_SRC      = 4,
  parameter int unsigned N_LINE     = 16,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_BYTES = 4,
  parameter logic [ADDR_W-1:0] BASE = 8'h60
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        src_lvl_i,
  input logic                    cfg_we_i,
  input logic [ADDR_W-1:0]       cfg_addr_i,
  input logic [8*DATA_BYTES-1:0] cfg_wdata_i,
  input logic [LEN_W-1:0]        cfg_len_i,
  input logic [N_LINE-1:0]       line_o,
  input route_t [N_SRC-1:0]      route_q
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  function automatic logic [N_LINE-1:0] want(input route_t [N_SRC-1:0] r, input logic [N_SRC-1:0] s);
    logic [N_LINE-1:0] w;
    w = '0;
    for (int i = 0; i < N_SRC; i++)
      for (int l = 0; l < N_LINE; l++)
        if (s[i] && (int'(r[i]) == l)) w[l] = 1'b1;
    return w;
  endfunction

  logic [EXT_W-1:0] lo, hi;
  logic             outside, all_off;
  assign lo      = {1'b0, cfg_addr_i};
  assign hi      = lo + EXT_W'(cfg_len_i);
  assign outside = (hi <= EXT_W'(BASE)) || (lo >= EXT_W'(BASE) + EXT_W'(N_SRC));
  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < N_SRC; i++) if (route_q[i] < ROUTE_W'(N_LINE)) all_off = 1'b0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_idle_r1: assert (line_o == '0);
  end

  p_line_or_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> line_o == want(route_q, $past(src_lvl_i)));

  p_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_off |-> line_o == '0);

  p_outside_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && outside) |=> $stable(route_q));

  p_bad_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !len_legal(cfg_len_i)) |=> $stable(route_q));

  p_byte_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_len_i == 3'd1 && cfg_addr_i == BASE) |=> route_q[0] == $past(cfg_wdata_i[7:0]));
endmodule

bind pirq_steer_router pirq_steer_router_chk #(
  .N_SRC(N_SRC), .N_LINE(N_LINE), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .BASE(BASE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_lvl_i  (src_lvl_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_len_i  (cfg_len_i),
  .line_o     (line_o),
  .route_q    (route_q)
);

// File: tb/tb_pirq_steer_router.sv
module tb_pirq_steer_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  len = '0;
  logic [7:0]  raddr = '0;
  logic [7:0]  rdata;
  logic [15:0] line;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pirq_steer_router dut (
    .clk_i(clk), .rst_ni(rst_n), .src_lvl_i(src), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_len_i(len),
    .cfg_raddr_i(raddr), .cfg_rdata_o(rdata), .line_o(line)
  );

  // reference model
  int          route_m [4];
  logic [15:0] exp_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 4; n++) route_m[n] = 8'h80;
      exp_m = '0;
    end else begin
      if (we && (len == 1 || len == 2 || len == 4)) begin
        for (int k = 0; k < int'(len); k++) begin
          int a;
          a = int'(addr) + k;
          if (a >= 'h60 && a <= 'h63) route_m[a - 'h60] = int'(wdata[8*k +: 8]);
        end
      end
      exp_m = '0;
      for (int s = 0; s < 4; s++) if (src[s] && route_m[s] < 16) exp_m[route_m[s]] = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && live) chk(line === exp_m, "R4 per-cycle", 32'(line), 32'(exp_m));

  task automatic wr(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; len = l; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_src(input logic [3:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    raddr = a;
    #1;
    chk(rdata === exp, tag, 32'(rdata), 32'(exp));
  endtask

  task automatic rd_all(input string tag);
    for (int n = 0; n < 4; n++) rd(8'(8'h60 + n), 8'(route_m[n]), tag);
  endtask

  task automatic lines(input logic [15:0] exp, input string tag);
    chk(line === exp, tag, 32'(line), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    lines(16'h0000, "R1 lines after reset");
    for (int n = 0; n < 4; n++) rd(8'(8'h60 + n), 8'h80, "R1 route reset value");
    rd(8'h64, 8'h00, "R2 read outside window");
    rd(8'h5F, 8'h00, "R2 read below window");

    set_src(4'hF);
    lines(16'h0000, "R3 all sources disabled");

    wr(8'h60, 3'd4, 32'h0B0A0503);
    lines(16'h0C28, "R6 rebuild after full write");
    rd(8'h60, 8'h03, "R2 byte0"); rd(8'h61, 8'h05, "R2 byte1");
    rd(8'h62, 8'h0A, "R2 byte2"); rd(8'h63, 8'h0B, "R2 byte3");

    set_src(4'hD);
    lines(16'h0C08, "R5 single line drops");

    wr(8'h61, 3'd1, 32'h00000003);
    lines(16'h0C08, "R6 move low source");
    set_src(4'hC); lines(16'h0C00, "R9 both sharers low");
    set_src(4'hE); lines(16'h0C08, "R9 one sharer high");
    set_src(4'hF); lines(16'h0C08, "R9 both sharers high");
    set_src(4'hD); lines(16'h0C08, "R9 one sharer drops");

    wr(8'h62, 3'd2, 32'h00000F10);
    lines(16'h8008, "R6 disable at 16 and route to 15");
    rd(8'h62, 8'h10, "R2 value 16 stored");
    set_src(4'h9); lines(16'h8008, "R3 disabled source falls");
    set_src(4'hD); lines(16'h8008, "R3 disabled source rises");

    wr(8'h5E, 3'd4, 32'h0607AAAA);
    lines(16'h8080, "R7 straddle low edge");
    rd(8'h60, 8'h07, "R7 low straddle byte2");
    rd(8'h61, 8'h06, "R7 low straddle byte3");
    rd(8'h62, 8'h10, "R7 low straddle untouched");

    wr(8'h62, 3'd4, 32'h55550201);
    lines(16'h0086, "R7 straddle high edge");
    rd_all("R7 high straddle routes");

    wr(8'h40, 3'd4, 32'h00000000);
    lines(16'h0086, "R7 write outside window");
    rd_all("R7 routes unchanged");

    wr(8'h60, 3'd3, 32'h00000000);
    lines(16'h0086, "R8 length 3 ignored");
    wr(8'h60, 3'd0, 32'h00000000);
    rd_all("R8 routes unchanged");

    // write and level change in the same cycle
    @(negedge clk);
    we = 1'b1; addr = 8'h60; len = 3'd1; wdata = 32'h00000001; src = 4'h5;
    @(negedge clk);
    we = 1'b0;
    lines(16'h0002, "R6 rebuild uses live levels");

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      src = 4'($urandom);
      we = ($urandom % 4) == 0;
      addr = 8'(8'h5C + ($urandom % 12));
      len = 3'($urandom % 6);
      wdata = $urandom;
      if (($urandom % 3) == 0) wdata = wdata & 32'h0F0F0F0F;
    end
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    rd_all("R2 routes after random run");

    rst_n = 1'b0;
    #1;
    lines(16'h0000, "R1 lines in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 4; n++) rd(8'(8'h60 + n), 8'h80, "R1 route after second reset");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule